// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block collects interrupt events from outside the chip and turns them into request lines for a small processor core. There is one dedicated interrupt pin with a two-bit sense mode. The mode selects one of four triggers: a held low level, any change, a falling edge or a rising edge. There are also up to four groups of eight general-purpose pins. Any change on a pin that is masked in raises that group's one shared request.

Every pin first passes through a two-flop synchroniser. Edge and change events are found by comparing the synchronised sample with the sample from the cycle before. An edge or change event sets a sticky flag, and the flag stays set until the matching acknowledge input clears it. A flag only reaches its request output when the global interrupt-enable input is high and the source's enable bit is set. Software configures the block through byte-wide registers on a plain write-strobe/read bus. The read data is combinational from the address.

Register map, with a 3-bit address: 0 is the sense control register, 1 is the enable register, and 2 to 5 are the per-pin mask registers for groups 0 to 3. Addresses 6 and 7 read as zero.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and every request output is low.
- R2: Sense control bits [1:0] can be written and read back. Bits [7:2] always read as zero.
- R3: Sense code 00 (low level) gives a request that follows the synchronised pin with no latching. The request rises two clock edges after the pin goes low and falls two edges after it returns high.
- R4: Sense code 01 sets the dedicated pin's flag on either a rising or a falling transition.
- R5: Sense code 10 sets the flag on a falling transition only.
- R6: Sense code 11 sets the flag on a rising transition only.
- R7: A flag stays set until its acknowledge input is high at a clock edge. If a new event occurs on the same edge as the acknowledge, the flag stays set.
- R8: A request output is high only while the global enable is high, the source's enable bit is set and its flag is set (or, in level mode, the pin is low). The dedicated pin's enable is bit 0 and group g's enable is bit 4+g. A flag still gets set while its request is masked, and it appears once the enables are set.
- R9: A change on a pin whose bit is set in its group's mask register sets that group's flag. A change on a pin whose mask bit is clear does not.
- R10: Writing the sense mode, the enable register or a pin mask while the pins are steady never sets a flag.
- R11: With the upper groups absent (HAS_UPPER=0), enable bits 7:6 and the mask registers for groups 2 and 3 read zero and ignore writes, and grp_req[3:2] stay low.
- R12: An edge or change event shows on its request output on the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| gie | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | Dedicated interrupt pin (asynchronous) |
| pc_pins | input | 32 | Pin-change inputs, group g on bits 8g+7:8g |
| ack_ext | input | 1 | Clears the dedicated pin's flag |
| ack_grp | input | 4 | Clears group g's flag on bit g |
| ext_req | output | 1 | Dedicated pin request |
| grp_req | output | 4 | Pin-change group requests |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a new event. The bench gets there by counting synchroniser stages: it toggles the pin and raises the acknowledge exactly two edges later. The bench also runs a sweep over all four sense codes with both pin transition directions, and a sweep over every pin of every group with a single-bit mask. Pin-mask and mode rewrites are made while the pins are held steady, and the bench shows at the request outputs that these writes raise no flag.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int GRP_MAX = 4;
  localparam int GRP_W   = 8;
  localparam int AW      = 3;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic [AW-1:0] A_SENSE = 3'd0;
  localparam logic [AW-1:0] A_EN    = 3'd1;
  localparam int            A_PM0   = 2;
  localparam int            EN_GRP_LSB = 4;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
  import xirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e mode,
  input  logic   ack,
  output logic   raw_o
);
  logic prev_q, flag_q, hit;

  always_comb begin
    unique case (mode)
      SNS_ANY:  hit = pin_s ^ prev_q;
      SNS_FALL: hit = prev_q & ~pin_s;
      SNS_RISE: hit = ~prev_q & pin_s;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (mode == SNS_LOW) flag_q <= 1'b0;
      else                 flag_q <= (flag_q & ~ack) | hit;
    end
  end

  assign raw_o = (mode == SNS_LOW) ? ~pin_s : flag_q;

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack && mode != SNS_LOW) |=> flag_q);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pin_s != prev_q));
  p_level_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LOW && $past(mode) == SNS_LOW && $rose(pin_s)) |-> !raw_o);
endmodule

// File: rtl/xirq_pcgroup.sv
module xirq_pcgroup #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] pmask,
  input  logic         ack,
  output logic         flag_o
);
  logic [W-1:0] prev_q;
  logic         flag_q;
  logic         hit;

  assign hit = |((pins_s ^ prev_q) & pmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      flag_q <= (flag_q & ~ack) | hit;
    end
  end

  assign flag_o = flag_q;

  p_grp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q);
  p_grp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(pins_s) != $past(prev_q)));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [AW-1:0]            bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic                     gie,
  input  logic                     ext_pin,
  input  logic [GRP_MAX*GRP_W-1:0] pc_pins,
  input  logic                     ack_ext,
  input  logic [GRP_MAX-1:0]       ack_grp,
  output logic                     ext_req,
  output logic [GRP_MAX-1:0]       grp_req
);
  localparam int          NGRP     = HAS_UPPER ? GRP_MAX : 2;
  localparam int          SYNC_W   = 1 + GRP_MAX*GRP_W;
  localparam logic [7:0]  EN_WMASK = HAS_UPPER ? 8'hF1 : 8'h31;

  sense_e                            sense_q;
  logic [7:0]                        en_q;
  logic [GRP_MAX-1:0][GRP_W-1:0]     pmask_q;
  logic [SYNC_W-1:0]                 sync_s;
  logic                              ext_raw;
  logic [GRP_MAX-1:0]                gflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= SNS_LOW;
      en_q    <= '0;
      pmask_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_SENSE) sense_q <= sense_e'(bus_wdata[1:0]);
      if (bus_addr == A_EN)    en_q    <= bus_wdata & EN_WMASK;
      for (int g = 0; g < GRP_MAX; g++) begin
        if (g < NGRP && bus_addr == AW'(A_PM0 + g)) pmask_q[g] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_SENSE) bus_rdata = {6'b0, sense_q};
    if (bus_addr == A_EN)    bus_rdata = en_q;
    for (int g = 0; g < GRP_MAX; g++) begin
      if (bus_addr == AW'(A_PM0 + g)) bus_rdata = pmask_q[g];
    end
  end

  xirq_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({pc_pins, ext_pin}), .q_o(sync_s)
  );

  xirq_sense u_sense (
    .clk(clk), .rst_n(rst_n), .pin_s(sync_s[0]), .mode(sense_q),
    .ack(ack_ext), .raw_o(ext_raw)
  );

  for (genvar g = 0; g < GRP_MAX; g++) begin : g_grp
    if (g < NGRP) begin : g_on
      xirq_pcgroup #(.W(GRP_W)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .pins_s(sync_s[1 + g*GRP_W +: GRP_W]),
        .pmask(pmask_q[g]), .ack(ack_grp[g]), .flag_o(gflag[g])
      );
    end else begin : g_off
      assign gflag[g] = 1'b0;
    end
    assign grp_req[g] = gie & en_q[EN_GRP_LSB + g] & gflag[g];
  end

  assign ext_req = gie & en_q[0] & ext_raw;

  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!ext_req && grp_req == '0));
  p_absent_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_UPPER && bus_we && bus_addr == A_EN) |=> (en_q[7:6] == 2'b00));
  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SENSE) |=> (sense_q == $past(bus_wdata[1:0])));
endmodule

// File: tb/xirq_ctrl_tb_top.sv
`timescale 1ns/100ps
module xirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata, rdata_lo;
  logic        gie = 1'b0;
  logic        ext_pin = 1'b0;
  logic [31:0] pc = '0;
  logic        ack_ext = 1'b0;
  logic [3:0]  ack_grp = '0;
  logic        ext_req, ext_req_lo;
  logic [3:0]  grp_req, grp_req_lo;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  xirq_ctrl #(.HAS_UPPER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .gie(gie), .ext_pin(ext_pin),
    .pc_pins(pc), .ack_ext(ack_ext), .ack_grp(ack_grp),
    .ext_req(ext_req), .grp_req(grp_req));

  xirq_ctrl #(.HAS_UPPER(1'b0)) dut_lo (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_lo), .gie(gie), .ext_pin(ext_pin),
    .pc_pins(pc), .ack_ext(ack_ext), .ack_grp(ack_grp),
    .ext_req(ext_req_lo), .grp_req(grp_req_lo));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [7:0] exp);
    bus_addr = a; #0.5;
    chk(tag, {24'b0, rdata}, {24'b0, exp});
  endtask

  task automatic ackx();
    ack_ext = 1'b1; ack_grp = 4'hF; tick(); ack_ext = 1'b0; ack_grp = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick();
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1 reg reset", 3'(a), 8'h00);
    chk("R1 req reset", {27'b0, ext_req, grp_req}, 32'h0);

    // R2 control register width
    wr(3'd0, 8'hFF); rd("R2 ctrl upper zero", 3'd0, 8'h03);
    wr(3'd0, 8'hFE); rd("R2 ctrl readback", 3'd0, 8'h02);

    gie = 1'b1; wr(3'd1, 8'hF1); rd("R8 enable readback", 3'd1, 8'hF1);

    // R3 level mode, unlatched
    wr(3'd0, 8'h00); ext_pin = 1'b1; tick(4);
    chk("R3 high no req", ext_req, 0);
    ext_pin = 1'b0; tick(1); chk("R3 not yet", ext_req, 0);
    tick(1); chk("R3 low req", ext_req, 1);
    ext_pin = 1'b1; tick(1); chk("R3 still low", ext_req, 1);
    tick(1); chk("R3 release", ext_req, 0);

    // R4 R5 R6 sweep: every mode, both transitions
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 2; a++) begin
        logic nv, exp;
        ext_pin = 1'(a); wr(3'd0, 8'(m)); tick(4); ackx(); tick();
        nv = ~1'(a);
        ext_pin = nv; tick(3);
        case (m)
          0: exp = ~nv;
          1: exp = 1'b1;
          2: exp = ~nv;
          default: exp = nv;
        endcase
        chk($sformatf("R4 R5 R6 mode=%0d to=%0d", m, nv), ext_req, exp);
        if (m != 0) begin
          ackx(); chk("R7 ack clears", ext_req, 0);
        end
      end
    end

    // R12 latency and R7 stickiness, mode any-change
    wr(3'd0, 8'h01); tick(3); ackx(); tick();
    ext_pin = ~ext_pin; tick(2); chk("R12 not before third edge", ext_req, 0);
    tick(1); chk("R12 third edge", ext_req, 1);
    tick(10); chk("R7 sticky", ext_req, 1);
    ackx(); chk("R7 cleared", ext_req, 0);

    // R7 event coincident with acknowledge
    ext_pin = ~ext_pin; tick(2);
    ack_ext = 1'b1; tick(); ack_ext = 1'b0;
    chk("R7 event wins over ack", ext_req, 1);
    ackx();

    // R8 gating: flag pends while masked
    wr(3'd1, 8'hF0); ext_pin = ~ext_pin; tick(4);
    chk("R8 masked by enable", ext_req, 0);
    gie = 1'b0; wr(3'd1, 8'hF1); chk("R8 masked by gie", ext_req, 0);
    gie = 1'b1; #0.5; chk("R8 pending appears", ext_req, 1);
    ackx();

    // R10 mode/mask rewrites with steady pins
    wr(3'd0, 8'h02); wr(3'd0, 8'h03); wr(3'd0, 8'h01);
    wr(3'd1, 8'h00); wr(3'd1, 8'hF1);
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'hFF);
    tick(4);
    chk("R10 no spurious ext", ext_req, 0);
    chk("R10 no spurious grp", grp_req, 0);
    pc = 32'h5A5A_A5A5; tick(4); ackx();
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'h00);
    for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'h3C);
    tick(4); chk("R10 pmask change no event", grp_req, 0);

    // R9 sweep: every pin of every group, single-bit mask
    for (int g = 0; g < 4; g++) begin
      for (int b = 0; b < 8; b++) wr(3'(2 + g), 8'h00);
      for (int b = 0; b < 8; b++) begin
        int ob;
        ob = (b + 1) % 8;
        wr(3'(2 + g), 8'(1 << b)); rd("R9 pmask readback", 3'(2 + g), 8'(1 << b));
        ackx();
        pc[g*8 + b] = ~pc[g*8 + b]; tick(3);
        chk($sformatf("R9 g%0d pin%0d in", g, b), grp_req, 32'(1 << g));
        ackx();
        pc[g*8 + ob] = ~pc[g*8 + ob]; tick(3);
        chk($sformatf("R9 g%0d pin%0d out", g, ob), grp_req, 0);
      end
      wr(3'(2 + g), 8'h00);
    end

    // R11 absent upper groups
    wr(3'd1, 8'hFF);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd2, 8'hFF);
    bus_addr = 3'd1; #0.5; chk("R11 en upper zero", rdata_lo, 8'h31);
    bus_addr = 3'd4; #0.5; chk("R11 pmask g2 zero", rdata_lo, 8'h00);
    bus_addr = 3'd5; #0.5; chk("R11 pmask g3 zero", rdata_lo, 8'h00);
    bus_addr = 3'd2; #0.5; chk("R11 pmask g0 kept", rdata_lo, 8'hFF);
    ackx();
    pc = ~pc; tick(4);
    chk("R11 upper req low", grp_req_lo[3:2], 0);
    chk("R11 lower req", grp_req_lo[0], 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule